// File: doc/BRIEF.md
# Single-Position Shift and Rotate Unit with Carry

This block is purely combinational. It moves an N-bit operand by one bit position in one of eight ways, chosen by a 3-bit operation code. The eight ways cover logical shifts, arithmetic shifts, plain rotates and rotates that pass through a carry bit. On the same evaluation it returns the moved word, a carry-out bit, a zero flag and a sign flag. Every operation defines the carry-out.

A datapath places the unit between its operand source and its flag register. For the two through-carry rotates it feeds the stored carry flag into the carry input. On every other operation the carry input is ignored. The unit holds no state and has no sequencing, so a result is valid as soon as its inputs are stable.

Top module: `srot_unit`

## Requirements
- R1: Operation code 000 (logical left) gives result = {opd[W-2:0], 0} and carry-out = opd[W-1].
- R2: Operation code 001 (logical right) gives result = {0, opd[W-1:1]} and carry-out = opd[0].
- R3: Operation code 010 (arithmetic left) gives exactly the result and carry-out of code 000.
- R4: Operation code 011 (arithmetic right) gives result = {opd[W-1], opd[W-1:1]}, which keeps the sign bit, and carry-out = opd[0].
- R5: Operation code 100 (rotate left) gives result = {opd[W-2:0], opd[W-1]} and carry-out = opd[W-1].
- R6: Operation code 101 (rotate right) gives result = {opd[0], opd[W-1:1]} and carry-out = opd[0].
- R7: Operation code 110 (rotate left through carry) gives result = {opd[W-2:0], cin} and carry-out = opd[W-1].
- R8: Operation code 111 (rotate right through carry) gives result = {cin, opd[W-1:1]} and carry-out = opd[0].
- R9: For operation codes 000 to 101 the carry input has no effect on any output.
- R10: The zero flag is 1 exactly when every bit of the result is 0.
- R11: The sign flag equals bit W-1 of the result.
- R12: All outputs follow their inputs within the same clock cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_i | input | WIDTH | Operand to be shifted or rotated |
| cin_i | input | 1 | Incoming carry flag, used only by the through-carry rotates |
| op_i | input | 3 | Operation code (see R1 to R8) |
| res_o | output | WIDTH | Shifted or rotated result |
| cout_o | output | 1 | Updated carry flag: the bit moved out of the operand |
| zero_o | output | 1 | Result is all zeros |
| sign_o | output | 1 | Most significant bit of the result |

## Verification
The bench builds two copies of the unit: one at the default width of 8 and one at a width of 5.

- **Width 8:** every operand, every operation code and both carry values are applied, so each fill rule, each carry-out and each flag is checked over the whole input space.
- **Width 5:** the same sweep runs over the operand's low five bits. This checks that the edge positions follow the parameter rather than a fixed bit index.

A few probes sample the outputs shortly after an input change, within the same cycle, to check that the unit has no latency.

// File: rtl/srot_pkg.sv
package srot_pkg;

    // Operation codes
    typedef enum logic [2:0] {
        OP_SHL = 3'b000,
        OP_SHR = 3'b001,
        OP_SAL = 3'b010,
        OP_SAR = 3'b011,
        OP_ROL = 3'b100,
        OP_ROR = 3'b101,
        OP_RCL = 3'b110,
        OP_RCR = 3'b111
    } srot_op_e;

    // Source of the bit that enters the vacated position
    typedef enum logic [1:0] {
        FILL_ZERO  = 2'd0,
        FILL_SIGN  = 2'd1,
        FILL_WRAP  = 2'd2,
        FILL_CARRY = 2'd3
    } fill_e;

    typedef struct packed {
        logic  to_left;
        fill_e fill;
    } srot_ctrl_t;

    typedef struct packed {
        logic zero;
        logic sign;
    } srot_flags_t;

    function automatic logic op_is_rotate(input srot_op_e op);
        return op[2];
    endfunction

    function automatic logic op_uses_carry(input srot_op_e op);
        return op[2] & op[1];
    endfunction

endpackage

// File: rtl/srot_decode.sv
module srot_decode
    import srot_pkg::*;
(
    input  srot_op_e   op_i,
    output srot_ctrl_t ctrl_o
);

    always_comb begin
        ctrl_o = '{to_left: 1'b1, fill: FILL_ZERO};
        unique case (op_i)
            OP_SHL, OP_SAL: ctrl_o = '{to_left: 1'b1, fill: FILL_ZERO};
            OP_SHR:         ctrl_o = '{to_left: 1'b0, fill: FILL_ZERO};
            OP_SAR:         ctrl_o = '{to_left: 1'b0, fill: FILL_SIGN};
            OP_ROL:         ctrl_o = '{to_left: 1'b1, fill: FILL_WRAP};
            OP_ROR:         ctrl_o = '{to_left: 1'b0, fill: FILL_WRAP};
            OP_RCL:         ctrl_o = '{to_left: 1'b1, fill: FILL_CARRY};
            OP_RCR:         ctrl_o = '{to_left: 1'b0, fill: FILL_CARRY};
            default:        ctrl_o = '{to_left: 1'b1, fill: FILL_ZERO};
        endcase
    end

    always_comb begin
        if (!$isunknown(op_i)) begin
            // R9
            carry_fill_only_rcx_chk: assert ((ctrl_o.fill == FILL_CARRY) == op_uses_carry(op_i));
            // R5
            wrap_only_rotate_chk: assert ((ctrl_o.fill == FILL_WRAP) -> op_is_rotate(op_i));
        end
    end

endmodule

// File: rtl/srot_shift.sv
module srot_shift
    import srot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opd_i,
    input  logic             cin_i,
    input  srot_ctrl_t       ctrl_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);

    localparam int MSB = WIDTH - 1;

    logic             fill_bit;
    logic [WIDTH-1:0] left_v;
    logic [WIDTH-1:0] right_v;

    always_comb begin
        unique case (ctrl_i.fill)
            FILL_ZERO:  fill_bit = 1'b0;
            FILL_SIGN:  fill_bit = opd_i[MSB];
            FILL_WRAP:  fill_bit = ctrl_i.to_left ? opd_i[MSB] : opd_i[0];
            FILL_CARRY: fill_bit = cin_i;
            default:    fill_bit = 1'b0;
        endcase
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_lo
            assign left_v[i] = fill_bit;
        end else begin : g_lo
            assign left_v[i] = opd_i[i-1];
        end
        if (i == MSB) begin : g_hi
            assign right_v[i] = fill_bit;
        end else begin : g_hi
            assign right_v[i] = opd_i[i+1];
        end
    end

    assign res_o  = ctrl_i.to_left ? left_v : right_v;
    assign cout_o = ctrl_i.to_left ? opd_i[MSB] : opd_i[0];

    always_comb begin
        if (!$isunknown({opd_i, cin_i, ctrl_i})) begin
            // R5 R6
            rotate_keeps_ones_chk: assert ((ctrl_i.fill != FILL_WRAP) ||
                ($countones(res_o) == $countones(opd_i)));
            // R7 R8
            carry_ring_ones_chk: assert ((ctrl_i.fill != FILL_CARRY) ||
                ($countones(res_o) + int'(cout_o) == $countones(opd_i) + int'(cin_i)));
            // R4
            sar_sign_kept_chk: assert ((ctrl_i.fill != FILL_SIGN) ||
                (res_o[MSB] == opd_i[MSB] && res_o[MSB-1] == opd_i[MSB]));
            // R1 R2
            zero_fill_drops_one_chk: assert ((ctrl_i.fill != FILL_ZERO) ||
                ($countones(res_o) + int'(cout_o) == $countones(opd_i)));
        end
    end

endmodule

// File: rtl/srot_flags.sv
module srot_flags
    import srot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] res_i,
    output srot_flags_t      flags_o
);

    assign flags_o.zero = ~|res_i;
    assign flags_o.sign = res_i[WIDTH-1];

endmodule

// File: rtl/srot_unit.sv
module srot_unit
    import srot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opd_i,
    input  logic             cin_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o,
    output logic             zero_o,
    output logic             sign_o
);

    srot_op_e    op_e;
    srot_ctrl_t  ctrl;
    srot_flags_t flags;

    assign op_e = srot_op_e'(op_i);

    srot_decode u_decode (
        .op_i   (op_e),
        .ctrl_o (ctrl)
    );

    srot_shift #(.WIDTH(WIDTH)) u_shift (
        .opd_i  (opd_i),
        .cin_i  (cin_i),
        .ctrl_i (ctrl),
        .res_o  (res_o),
        .cout_o (cout_o)
    );

    srot_flags #(.WIDTH(WIDTH)) u_flags (
        .res_i   (res_o),
        .flags_o (flags)
    );

    assign zero_o = flags.zero;
    assign sign_o = flags.sign;

    always_comb begin
        if (!$isunknown({opd_i, cin_i, op_i})) begin
            // R10
            zero_rotate_chk: assert (!(zero_o && op_i[2] && !op_i[1]) || (opd_i == '0));
            // R11
            sign_left_chk: assert ((ctrl.to_left == 1'b0) || (sign_o == opd_i[WIDTH-2]));
            // R3
            sal_eq_shl_chk: assert ((op_i != 3'b010) || (res_o == {opd_i[WIDTH-2:0], 1'b0}));
        end
    end

endmodule

// File: tb/srot_unit_tb_top.sv
module srot_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W_A = 8;
    localparam int W_B = 5;
    localparam int WATCHDOG_CYC = 200000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W_A-1:0] opd_a;
    logic [W_B-1:0] opd_b;
    logic           cin;
    logic [2:0]     op;
    logic [W_A-1:0] res_a;
    logic [W_B-1:0] res_b;
    logic           cout_a, zero_a, sign_a;
    logic           cout_b, zero_b, sign_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    srot_unit #(.WIDTH(W_A)) dut_i (
        .opd_i (opd_a), .cin_i (cin), .op_i (op),
        .res_o (res_a), .cout_o (cout_a), .zero_o (zero_a), .sign_o (sign_a)
    );

    srot_unit #(.WIDTH(W_B)) dut_n_i (
        .opd_i (opd_b), .cin_i (cin), .op_i (op),
        .res_o (res_b), .cout_o (cout_b), .zero_o (zero_b), .sign_o (sign_b)
    );

    // Behavioural reference, written from the requirement text
    function automatic void ref_model(input int w, input int code, input int a, input int c,
                                      output int r, output int co);
        int mask = (1 << w) - 1;
        int hi   = (a >> (w - 1)) & 1;
        int lo   = a & 1;
        case (code)
            0, 2: begin r = (a << 1) & mask;                   co = hi; end
            1:    begin r = a >> 1;                            co = lo; end
            3:    begin r = (a >> 1) | (hi << (w - 1));        co = lo; end
            4:    begin r = ((a << 1) & mask) | hi;            co = hi; end
            5:    begin r = (a >> 1) | (lo << (w - 1));        co = lo; end
            6:    begin r = ((a << 1) & mask) | c;             co = hi; end
            default: begin r = (a >> 1) | (c << (w - 1));     co = lo; end
        endcase
    endfunction

    function automatic string op_tag(input int code, input int c);
        string s;
        case (code)
            0: s = "R1"; 1: s = "R2"; 2: s = "R3"; 3: s = "R4";
            4: s = "R5"; 5: s = "R6"; 6: s = "R7"; default: s = "R8";
        endcase
        if (code < 6 && c == 1) s = {s, "/R9"};
        return s;
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s op=%0d cin=%0d opd=%0h: actual %0h expected %0h",
                     tag, op, cin, opd_a, act, exp);
        end
    endtask

    task automatic check_one(input int w, input int a, input int r_act, input int c_act,
                             input int z_act, input int s_act);
        int r_exp, c_exp;
        ref_model(w, int'(op), a, int'(cin), r_exp, c_exp);
        cmp($sformatf("%s w%0d result", op_tag(int'(op), int'(cin)), w), r_act, r_exp);
        cmp($sformatf("%s w%0d carry", op_tag(int'(op), int'(cin)), w), c_act, c_exp);
        cmp($sformatf("R10 w%0d zero", w), z_act, int'(r_exp == 0));
        cmp($sformatf("R11 w%0d sign", w), s_act, (r_exp >> (w - 1)) & 1);
    endtask

    task automatic check_both();
        check_one(W_A, int'(opd_a), int'(res_a), int'(cout_a), int'(zero_a), int'(sign_a));
        check_one(W_B, int'(opd_b), int'(res_b), int'(cout_b), int'(zero_b), int'(sign_b));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        opd_a = '0; opd_b = '0; cin = 1'b0; op = 3'b000;

        // Exhaustive sweep: drive after a rising edge, compare at the falling edge
        for (int code = 0; code < 8; code++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < (1 << W_A); a++) begin
                    @(posedge clk);
                    #1;
                    op    = 3'(code);
                    cin   = 1'(c);
                    opd_a = W_A'(a);
                    opd_b = W_B'(a);
                    @(negedge clk);
                    check_both();
                end
            end
        end

        // R12: outputs follow an input change within the same cycle
        @(posedge clk);
        #1;
        op = 3'b111; cin = 1'b1; opd_a = '0; opd_b = '0;
        #1;
        cmp("R12 rcr fill seen same cycle", int'(res_a), 32'h80);
        cmp("R12 sign same cycle", int'(sign_a), 1);
        op = 3'b011; opd_a = 8'h81; opd_b = 5'h11;
        #1;
        cmp("R12 sar same cycle", int'(res_a), 32'hC0);
        cmp("R12 sar carry same cycle", int'(cout_a), 1);
        // R9 corner: carry set on a plain rotate of zero stays zero
        op = 3'b100; cin = 1'b1; opd_a = '0; opd_b = '0;
        #1;
        cmp("R9 rol ignores cin", int'(res_a), 0);
        cmp("R10 rol zero flag", int'(zero_a), 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG_CYC; i++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule